// File: doc/BRIEF.md
# Memory-Mapped 2x2 Matrix-Multiply Accelerator

This block is a slave on a simple CPU data bus. Software stores two 2x2 operand matrices into write-only word registers and writes a start bit. The block then multiplies the matrices over several cycles in a small output-stationary systolic grid while the CPU keeps running. Software learns that the job is finished by polling a status word. It then reads the four result words.

Each bus access takes one cycle. Writes land on the rising clock edge. Reads are combinational from registered state, so the data is valid in the same cycle as the access. Before the grid starts, a run takes a private copy of both operands. Stores that software makes to the operand registers during a run therefore only affect the next run.

Top module: `mmio_matmul2x2`

## Requirements
- R1: The block responds only when bus_addr[31] is 1. An access with bit 31 at 0 writes nothing and reads 0.
- R2: A hit is an address with bit 31 set, bits 30..6 clear and bits 1..0 clear. The word index is bus_addr[5:2]. Indices 0..3 (byte offsets 0x00..0x0C) hold the left operand A. Indices 4..7 (0x10..0x1C) hold the right operand B. Both are row-major: element [0][0], then [0][1], then [1][0], then [1][1].
- R3: A write to index 8 (0x20) with wdata bit 0 set starts a run. With bit 0 clear, the write does nothing.
- R4: The status word is index 9 (0x24), and its bit 0 is the done flag. The edge that accepts a start clears the flag. The flag reads 1 from the sixth rising edge after that edge, and it stays 1 until the next accepted start.
- R5: The result words are indices 12..15 (0x30..0x3C), row-major. They hold A x B, with each element a 32-bit two's-complement sum of products that wraps modulo 2^32.
- R6: Operand writes made after the start edge do not affect the run in progress. They are used by the next run.
- R7: A start written while a run is in progress is ignored. The run keeps its original timing.
- R8: A read returns 0 in each of these cases: bus_re is low, the address is not a hit, or the index is a write-only or unused offset (A, B, control, 10, 11).
- R9: Writes to the status word, the result words or unused indices change nothing.
- R10: A synchronous active-low reset clears the operands, the results, the done flag and any run in progress.
- R11: The result words change only on the edge where the done flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |

## Verification
The bench goes after the cases a careless design gets wrong:
- **Signed operands whose products overflow.** A design with a wrong accumulator width or sign handling returns a wrong low word.
- **Operand store in the cycle after a start.** A design that feeds the grid from the live registers computes with the new value.
- **Second start during a run.** A design that accepts it restarts, and done arrives late.
- **Stores and loads with bit 31 clear, misaligned or beyond the map.** A loose decoder writes a register or returns a stale value.
- **Reset in the middle of a run.** A design that misses it leaves done or the results set.

The status word is read in almost every cycle, so a done flag that rises one edge early or late is caught at the exact cycle.

// File: rtl/mm_pkg.sv
// Shared types for the 2x2 matrix-multiply accelerator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mm_pkg;
    // Sequencer phases: waiting, operand capture, array stepping, result latch.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_COMPUTE = 2'd2,
        ST_DONE    = 2'd3
    } mm_state_t;
endpackage

// File: rtl/mm_pe.sv
// One processing element of the output-stationary grid: multiplies the
// operands arriving from the left and the top, adds the product to a local
// accumulator and forwards both operands one cycle later.
// Assumes: clr and en are never high together in a useful way (clr wins).
module mm_pe #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] b_out,
    output logic [DW-1:0] acc
);
    // Multiply-accumulate and operand forwarding, wrapping modulo 2^DW.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            a_out <= '0;
            b_out <= '0;
            acc   <= '0;
        end else if (en) begin
            a_out <= a_in;
            b_out <= b_in;
            acc   <= acc + a_in * b_in;
        end
    end
endmodule

// File: rtl/mm_array.sv
// NxN systolic multiply grid with skewed edge feeds. It keeps a private
// copy of the operands taken at load, steps while en is high, and copies
// the accumulators into the result register when latch is high.
// Assumes: step counts 0..3N-3 across the enabled cycles of one run.
module mm_array #(
    parameter int unsigned DW = 32,
    parameter int unsigned N  = 2,
    parameter int unsigned SW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  en,
    input  logic                  latch,
    input  logic [SW-1:0]         step,
    input  logic [N*N-1:0][DW-1:0] a_mat,
    input  logic [N*N-1:0][DW-1:0] b_mat,
    output logic [N*N-1:0][DW-1:0] c_mat
);
    localparam int unsigned NE = N * N;

    logic [NE-1:0][DW-1:0] a_w, b_w;
    logic [DW-1:0] a_feed [N];
    logic [DW-1:0] b_feed [N];
    logic [DW-1:0] a_lnk  [N][N+1];
    logic [DW-1:0] b_lnk  [N+1][N];
    logic [DW-1:0] acc_w  [N][N];

    // Snapshot the operands so later bus writes cannot disturb the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_w <= '0;
            b_w <= '0;
        end else if (load) begin
            a_w <= a_mat;
            b_w <= b_mat;
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_rowfeed
        // Row r enters r cycles late: element [r][k] at step r+k.
        always_comb begin
            a_feed[r] = '0;
            for (int k = 0; k < N; k++)
                if (int'(step) == r + k) a_feed[r] = a_w[r*N + k];
        end
        assign a_lnk[r][0] = a_feed[r];
    end

    for (genvar c = 0; c < N; c++) begin : g_colfeed
        // Column c enters c cycles late: element [k][c] at step c+k.
        always_comb begin
            b_feed[c] = '0;
            for (int k = 0; k < N; k++)
                if (int'(step) == c + k) b_feed[c] = b_w[k*N + c];
        end
        assign b_lnk[0][c] = b_feed[c];
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            mm_pe #(.DW(DW)) u_pe (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (load),
                .en    (en),
                .a_in  (a_lnk[r][c]),
                .b_in  (b_lnk[r][c]),
                .a_out (a_lnk[r][c+1]),
                .b_out (b_lnk[r+1][c]),
                .acc   (acc_w[r][c])
            );
        end
    end

    // Latch the finished accumulators into the readable result words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_mat <= '0;
        end else if (latch) begin
            for (int e = 0; e < int'(NE); e++) c_mat[e] <= acc_w[e / N][e % N];
        end
    end
endmodule

// File: rtl/mm_ctrl.sv
// Run sequencer: IDLE -> LOAD -> COMPUTE (STEPS cycles) -> DONE -> IDLE.
// It owns the sticky done flag.
// Assumes: start is a single-cycle request; it is ignored outside IDLE.
module mm_ctrl #(
    parameter int unsigned STEPS = 4,
    parameter int unsigned SW    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output mm_pkg::mm_state_t  state,
    output logic [SW-1:0]      step,
    output logic               load,
    output logic               en,
    output logic               latch,
    output logic               done
);
    import mm_pkg::*;

    localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

    // Advance the run phases and keep the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_LOAD;
                    done  <= 1'b0;
                end
                ST_LOAD: begin
                    state <= ST_COMPUTE;
                    step  <= '0;
                end
                ST_COMPUTE: begin
                    if (step == LAST_STEP) state <= ST_DONE;
                    else                   step  <= step + 1'b1;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase strobes for the grid.
    assign load  = (state == ST_LOAD);
    assign en    = (state == ST_COMPUTE);
    assign latch = (state == ST_DONE);
endmodule

// File: rtl/mm_regs.sv
// Bus decode and register file: write-only operand words, a control word
// that turns into a start pulse, and a read mux over status and results.
// Assumes: 32-bit word-aligned accesses, one per cycle.
module mm_regs #(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned NE   = 4,
    parameter int unsigned OFFW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_we,
    input  logic                 bus_re,
    output logic [DW-1:0]        bus_rdata,
    input  logic                 done,
    input  logic [NE-1:0][DW-1:0] c_mat,
    output logic [NE-1:0][DW-1:0] a_mat,
    output logic [NE-1:0][DW-1:0] b_mat,
    output logic                 start
);
    localparam int unsigned A_BASE   = 0;
    localparam int unsigned B_BASE   = NE;
    localparam int unsigned CTRL_IDX = 2 * NE;
    localparam int unsigned STAT_IDX = 2 * NE + 1;
    localparam int unsigned C_BASE   = 3 * NE;

    logic            hit;
    logic [OFFW-3:0] word;

    // Top bit selects the block; the rest above the offset must be zero.
    assign hit  = bus_addr[AW-1] && (bus_addr[AW-2:OFFW] == '0) && (bus_addr[1:0] == 2'b00);
    assign word = bus_addr[OFFW-1:2];
    assign start = bus_we && hit && (int'(word) == CTRL_IDX) && bus_wdata[0];

    // Store operand words; other indices are not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_mat <= '0;
            b_mat <= '0;
        end else if (bus_we && hit) begin
            for (int e = 0; e < int'(NE); e++) begin
                if (int'(word) == A_BASE + e) a_mat[e] <= bus_wdata;
                if (int'(word) == B_BASE + e) b_mat[e] <= bus_wdata;
            end
        end
    end

    // Same-cycle read mux; everything not readable returns zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_re && hit) begin
            if (int'(word) == STAT_IDX) bus_rdata = {{(DW-1){1'b0}}, done};
            for (int e = 0; e < int'(NE); e++)
                if (int'(word) == C_BASE + e) bus_rdata = c_mat[e];
        end
    end
endmodule

// File: rtl/mmio_matmul2x2.sv
// Memory-mapped 2x2 matrix-multiply accelerator: register file, run
// sequencer and systolic grid.
// Assumes: N = 2, so that the map fits the 6-bit offset window.
module mmio_matmul2x2 #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned N  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata
);
    localparam int unsigned NE    = N * N;
    localparam int unsigned OFFW  = $clog2(4 * NE) + 2;
    localparam int unsigned STEPS = 3 * N - 2;
    localparam int unsigned SW    = $clog2(STEPS + 1);

    logic [NE-1:0][DW-1:0] a_w, b_w, c_w;
    logic                  start_w, load_w, en_w, latch_w, done_w;
    logic [SW-1:0]         step_w;
    mm_pkg::mm_state_t     ctrl_state;

    mm_regs #(.AW(AW), .DW(DW), .NE(NE), .OFFW(OFFW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .done      (done_w),
        .c_mat     (c_w),
        .a_mat     (a_w),
        .b_mat     (b_w),
        .start     (start_w)
    );

    mm_ctrl #(.STEPS(STEPS), .SW(SW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_w),
        .state (ctrl_state),
        .step  (step_w),
        .load  (load_w),
        .en    (en_w),
        .latch (latch_w),
        .done  (done_w)
    );

    mm_array #(.DW(DW), .N(N), .SW(SW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .en    (en_w),
        .latch (latch_w),
        .step  (step_w),
        .a_mat (a_w),
        .b_mat (b_w),
        .c_mat (c_w)
    );
endmodule

// File: rtl/mm_checker.sv
// Protocol and sequencing properties for mmio_matmul2x2, attached by bind.
// Assumes: reset is synchronous and active low.
module mm_checker #(
    parameter int unsigned DW = 32,
    parameter int unsigned NE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_re,
    input logic              sel,
    input logic [DW-1:0]     bus_rdata,
    input mm_pkg::mm_state_t state,
    input logic              start,
    input logic              done,
    input logic [NE*DW-1:0]  c_flat
);
    import mm_pkg::*;

    // R1 / R8: no read strobe or no select means a zero bus.
    a_r8_quiet_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_re || !sel) |-> (bus_rdata == '0));

    // R4: done only falls on the edge after an accepted start.
    a_r4_done_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(state == ST_IDLE && start));

    // R4: done only rises out of the result-latch phase.
    a_r4_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state == ST_DONE));

    // R4: done is low throughout capture and stepping.
    a_r4_done_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD || state == ST_COMPUTE) |-> !done);

    // R7: a running job is never restarted.
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPUTE) |=> (state == ST_COMPUTE || state == ST_DONE));

    // R11: results only move when done rises.
    a_r11_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> $stable(c_flat));
endmodule

bind mmio_matmul2x2 mm_checker #(.DW(DW), .NE(NE)) u_mm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_re    (bus_re),
    .sel       (bus_addr[AW-1]),
    .bus_rdata (bus_rdata),
    .state     (ctrl_state),
    .start     (start_w),
    .done      (done_w),
    .c_flat    (c_w)
);

// File: tb/mmio_matmul2x2_tb_top.sv
// Self-checking bench: a behavioural model of the register map is updated
// on every edge, and bus_rdata is compared against it on every cycle.
module mmio_matmul2x2_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0, wdata = '0, rdata;
    logic        we = 1'b0, re = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] ma [4], mb [4], mc [4], sa [4], sb [4];
    bit          mdone;
    int          mcount;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_matmul2x2 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_re    (re),
        .bus_rdata (rdata)
    );

    function automatic bit is_hit(input logic [31:0] a);
        return a[31] && (a[30:6] == '0) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] exp_read(input bit r, input logic [31:0] a);
        int w;
        if (!r || !is_hit(a)) return '0;
        w = int'(a[5:2]);
        if (w == 9) return {31'b0, mdone};
        if (w >= 12) return mc[w-12];
        return '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            ma[i] = '0; mb[i] = '0; mc[i] = '0; sa[i] = '0; sb[i] = '0;
        end
        mdone = 0;
        mcount = 0;
    endtask

    task automatic model_edge(input bit w, input logic [31:0] a, input logic [31:0] d);
        int idx;
        bit go;
        go = 0;
        if (w && is_hit(a)) begin
            idx = int'(a[5:2]);
            if (idx < 4) ma[idx] = d;
            else if (idx < 8) mb[idx-4] = d;
            else if (idx == 8 && d[0] && mcount == 0) go = 1;
        end
        if (go) begin
            for (int i = 0; i < 4; i++) begin sa[i] = ma[i]; sb[i] = mb[i]; end
            mcount = LAT;
            mdone = 0;
        end else if (mcount > 0) begin
            mcount--;
            if (mcount == 0) begin
                mdone = 1;
                for (int i = 0; i < 2; i++)
                    for (int j = 0; j < 2; j++)
                        mc[i*2+j] = sa[i*2]*sb[j] + sa[i*2+1]*sb[2+j];
            end
        end
    endtask

    // One bus cycle: drive, compare against the model, then let the edge pass.
    task automatic bus(input bit w, input bit r, input logic [31:0] a,
                       input logic [31:0] d, input string tag, output logic [31:0] got);
        logic [31:0] e;
        @(negedge clk);
        we = w; re = r; addr = a; wdata = d;
        #1;
        e = exp_read(r, a);
        got = rdata;
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, e);
        end
        @(posedge clk);
        model_edge(w, a, d);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        logic [31:0] g;
        bus(1'b1, 1'b0, a, d, tag, g);
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] v, input string tag);
        logic [31:0] g;
        bus(1'b0, 1'b1, a, '0, tag, g);
        checks++;
        if (g !== v) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, g, v);
        end
    endtask

    task automatic idle(input int n, input string tag);
        logic [31:0] g;
        for (int i = 0; i < n; i++) bus(1'b0, 1'b1, BASE + 32'h24, '0, tag, g);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0; re = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_mats(input logic [31:0] a0, a1, a2, a3, b0, b1, b2, b3, input string tag);
        wr(BASE + 32'h00, a0, tag); wr(BASE + 32'h04, a1, tag);
        wr(BASE + 32'h08, a2, tag); wr(BASE + 32'h0C, a3, tag);
        wr(BASE + 32'h10, b0, tag); wr(BASE + 32'h14, b1, tag);
        wr(BASE + 32'h18, b2, tag); wr(BASE + 32'h1C, b3, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] g;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(BASE + 32'h24, 32'd0, "R10");
        rd(BASE + 32'h30, 32'd0, "R10");
        rd(BASE + 32'h3C, 32'd0, "R10");

        // R2 / R3 / R4 / R5: reference product
        load_mats(1, 2, 3, 4, 5, 6, 7, 8, "R2");
        wr(BASE + 32'h20, 32'd1, "R3");
        idle(LAT + 1, "R4");
        rd(BASE + 32'h30, 32'd19, "R5");
        rd(BASE + 32'h34, 32'd22, "R5");
        rd(BASE + 32'h38, 32'd43, "R5");
        rd(BASE + 32'h3C, 32'd50, "R5");
        idle(5, "R4");
        rd(BASE + 32'h24, 32'd1, "R4");

        // R8: write-only, unmapped, misaligned and strobe-low reads
        rd(BASE + 32'h00, 32'd0, "R8");
        rd(BASE + 32'h14, 32'd0, "R8");
        rd(BASE + 32'h20, 32'd0, "R8");
        rd(BASE + 32'h28, 32'd0, "R8");
        rd(BASE + 32'h40, 32'd0, "R8");
        rd(BASE + 32'h32, 32'd0, "R8");
        bus(1'b0, 1'b0, BASE + 32'h30, '0, "R8", g);

        // R1: bit 31 clear neither writes nor starts nor reads
        wr(32'h0000_0000, 32'd99, "R1");
        wr(32'h0000_0020, 32'd1, "R1");
        idle(3, "R1");
        rd(32'h0000_0024, 32'd0, "R1");

        // R9: writes to read-only words are dropped
        wr(BASE + 32'h30, 32'hDEAD_BEEF, "R9");
        wr(BASE + 32'h24, 32'd0, "R9");
        wr(BASE + 32'h2C, 32'd7, "R9");
        rd(BASE + 32'h30, 32'd19, "R9");
        rd(BASE + 32'h24, 32'd1, "R9");

        // R3: control write with bit 0 clear does not start
        wr(BASE + 32'h20, 32'd2, "R3");
        idle(3, "R3");

        // R1 check that A[0][0] kept 1: rerun and expect 19 again
        wr(BASE + 32'h20, 32'd1, "R1");
        idle(LAT + 1, "R1");
        rd(BASE + 32'h30, 32'd19, "R1");

        // R5 wrap / R6 late operand write / R7 start while busy
        load_mats(32'hFFFF_FFFF, 32'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFD,
                  32'd3, 32'hFFFF_FFFC, 32'd2, 32'd5, "R5");
        wr(BASE + 32'h20, 32'd1, "R5");
        wr(BASE + 32'h00, 32'd1000, "R6");
        wr(BASE + 32'h20, 32'd1, "R7");
        idle(LAT, "R7");
        rd(BASE + 32'h30, 32'h0000_0001, "R6");
        rd(BASE + 32'h34, 32'h0000_000E, "R5");
        rd(BASE + 32'h38, 32'h7FFF_FFF7, "R5");
        rd(BASE + 32'h3C, 32'hFFFF_FFF5, "R5");

        // R6: the late write is used by the next run; R4 back-to-back start
        wr(BASE + 32'h20, 32'd1, "R4");
        rd(BASE + 32'h24, 32'd0, "R4");
        idle(LAT, "R4");
        rd(BASE + 32'h30, 32'd3004, "R6");
        rd(BASE + 32'h30, 32'd3004, "R11");

        // R10: reset during a run
        wr(BASE + 32'h20, 32'd1, "R10");
        idle(2, "R10");
        do_reset();
        rd(BASE + 32'h24, 32'd0, "R10");
        rd(BASE + 32'h30, 32'd0, "R10");
        idle(LAT + 2, "R10");
        rd(BASE + 32'h30, 32'd0, "R10");

        summary();
    end
endmodule